// File: doc/BRIEF.md
# Aligned write request splitter

The splitter takes one host write of a contiguous byte range and turns it into a chain of device commands for a downstream command sequencer. Each step looks at the running device address. If that address sits on a write-buffer boundary, the step issues a buffered overwrite. That command covers as many bytes as remain, up to one buffer, and it carries the byte count and a payload offset, so the sequencer fetches the bytes itself. If the address is off a boundary, the step issues a single-word overwrite. For that command the splitter reads one bus word of payload bytes through its own byte-read port and packs them little-endian.

Only one command is outstanding at a time. After a command is accepted, the splitter waits for the sequencer's done pulse. It then advances the address and the completed-byte count and picks the next step. An error flagged with the done pulse ends the request at once, and the completion report then carries the number of bytes that had finished before the failing command. A zero-length request completes at once and issues nothing.

Top module: `wr_splitter`

## Requirements
- R1: After reset, req_ready_o is 1, and cmd_valid_o and fin_valid_o are 0.
- R2: When the current address is not a multiple of the buffer size, the splitter issues cmd_code_o = 0x42 at that address with cmd_count_o = 0. cmd_data_o holds BUS_BYTES payload bytes read from offsets done .. done+BUS_BYTES-1, and the byte at the lowest offset sits in bits [7:0].
- R3: After a single-word command completes without error, the address and the completed count each grow by BUS_BYTES.
- R4: When the current address is a multiple of the buffer size, the splitter issues cmd_code_o = 0xEA with cmd_count_o = min(remaining, buffer size), cmd_ptr_o = bytes completed so far, and cmd_data_o = 0.
- R5: After a buffered command completes without error, the address and the completed count each grow by that command's count.
- R6: done_i with err_i high ends the request. fin_err_o is then 1 and fin_count_o is the count completed before the failing command. No further command is issued.
- R7: The buffer size is BUF_WORDS*BUS_BYTES bytes. With the defaults that is 512*4 = 2048 bytes.
- R8: A request of length 0 gives a fin_valid_o pulse in the cycle after acceptance, with fin_count_o = 0 and fin_err_o = 0, and no command.
- R9: cmd_valid_o and all command fields hold steady until cmd_ready_i. After acceptance, no new command appears until done_i.
- R10: Completion is a one-cycle fin_valid_o pulse. Without an error, fin_count_o is at least the requested length, and it exceeds the length when a single-word step runs past the end. req_ready_o is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Splitter idle, request taken |
| req_addr_i | input | ADDR_W | Device start address in bytes |
| req_len_i | input | LEN_W | Length in bytes |
| pay_addr_o | output | LEN_W+1 | Payload byte offset being read |
| pay_data_i | input | 8 | Payload byte at pay_addr_o, same cycle |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Sequencer takes command |
| cmd_code_o | output | 8 | 0x42 single-word, 0xEA buffered |
| cmd_addr_o | output | ADDR_W | Device address of the step |
| cmd_data_o | output | 8*BUS_BYTES | Packed word for single-word steps |
| cmd_count_o | output | LEN_W+1 | Byte count of buffered steps |
| cmd_ptr_o | output | LEN_W+1 | Payload offset of the step |
| done_i | input | 1 | Sequencer finished the command |
| err_i | input | 1 | Failure, valid with done_i |
| fin_valid_o | output | 1 | Request complete pulse |
| fin_count_o | output | LEN_W+1 | Bytes written |
| fin_err_o | output | 1 | Request ended on error |

## Verification
Two events can meet in one done pulse: the last chunk of a request completes, and that chunk fails. Length-based completion and error termination then compete for the same cycle. The bench sends a request that fits in a single buffered command and answers it with done and error together, and it does the same on the middle command of a longer request. The completion report must show the error flag and the count from before the failing chunk, not the advanced count.

// File: rtl/wr_split_pkg.sv
package wr_split_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_GATHER,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } split_state_e;

  localparam logic [7:0] OP_WORD = 8'h42;
  localparam logic [7:0] OP_BUF  = 8'hEA;
endpackage

// File: rtl/wr_split_step.sv
module wr_split_step #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 17,
  parameter int BUF_BYTES = 2048
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  remain_i,
  output logic              aligned_o,
  output logic [CNT_W-1:0]  chunk_o
);
  localparam int ALIGN_W = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
  localparam logic [CNT_W-1:0] BUF_LEN = CNT_W'(BUF_BYTES);

  assign aligned_o = (addr_i[ALIGN_W-1:0] == '0);
  assign chunk_o   = (remain_i < BUF_LEN) ? remain_i : BUF_LEN;
endmodule

// File: rtl/wr_split_pack.sv
module wr_split_pack #(
  parameter int BUS_BYTES = 4,
  parameter int CNT_W     = 17
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   en_i,
  input  logic [7:0]             byte_i,
  input  logic [CNT_W-1:0]       base_i,
  output logic [CNT_W-1:0]       rd_addr_o,
  output logic [BUS_BYTES*8-1:0] word_o,
  output logic                   last_o
);
  localparam int IDX_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;

  logic [IDX_W-1:0] idx_q;

  assign last_o    = (idx_q == IDX_W'(BUS_BYTES - 1));
  assign rd_addr_o = base_i + CNT_W'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (en_i)   idx_q <= last_o ? '0 : idx_q + 1'b1;
  end

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             lane_q <= '0;
      else if (en_i && idx_q == IDX_W'(g))     lane_q <= byte_i;
    end
    assign word_o[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/wr_splitter.sv
module wr_splitter
  import wr_split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUS_BYTES = 4,
  parameter int BUF_WORDS = 512
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [LEN_W-1:0]       req_len_i,
  output logic [LEN_W:0]         pay_addr_o,
  input  logic [7:0]             pay_data_i,
  output logic                   cmd_valid_o,
  input  logic                   cmd_ready_i,
  output logic [7:0]             cmd_code_o,
  output logic [ADDR_W-1:0]      cmd_addr_o,
  output logic [BUS_BYTES*8-1:0] cmd_data_o,
  output logic [LEN_W:0]         cmd_count_o,
  output logic [LEN_W:0]         cmd_ptr_o,
  input  logic                   done_i,
  input  logic                   err_i,
  output logic                   fin_valid_o,
  output logic [LEN_W:0]         fin_count_o,
  output logic                   fin_err_o
);
  localparam int CNT_W     = LEN_W + 1;
  localparam int BUF_BYTES = BUF_WORDS * BUS_BYTES;
  localparam int ALIGN_W   = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;

  split_state_e           state_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [CNT_W-1:0]       len_q, done_q, step_q;
  logic                   word_q, err_q;
  logic                   aligned;
  logic [CNT_W-1:0]       chunk, next_done;
  logic [BUS_BYTES*8-1:0] packed_word;
  logic                   pack_last;

  wr_split_step #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .BUF_BYTES(BUF_BYTES)
  ) i_step (
    .addr_i   (addr_q),
    .remain_i (len_q - done_q),
    .aligned_o(aligned),
    .chunk_o  (chunk)
  );

  wr_split_pack #(
    .BUS_BYTES(BUS_BYTES),
    .CNT_W    (CNT_W)
  ) i_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_PLAN),
    .en_i     (state_q == ST_GATHER),
    .byte_i   (pay_data_i),
    .base_i   (done_q),
    .rd_addr_o(pay_addr_o),
    .word_o   (packed_word),
    .last_o   (pack_last)
  );

  assign next_done = done_q + step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      done_q  <= '0;
      step_q  <= '0;
      word_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          len_q   <= CNT_W'(req_len_i);
          done_q  <= '0;
          err_q   <= 1'b0;
          state_q <= (req_len_i == '0) ? ST_FIN : ST_PLAN;
        end
        ST_PLAN: begin
          word_q  <= ~aligned;
          step_q  <= aligned ? chunk : CNT_W'(BUS_BYTES);
          state_q <= aligned ? ST_ISSUE : ST_GATHER;
        end
        ST_GATHER: if (pack_last) state_q <= ST_ISSUE;
        ST_ISSUE:  if (cmd_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (done_i) begin
          if (err_i) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            addr_q  <= addr_q + ADDR_W'(step_q);
            done_q  <= next_done;
            state_q <= (next_done >= len_q) ? ST_FIN : ST_PLAN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cmd_valid_o = (state_q == ST_ISSUE);
  assign cmd_code_o  = word_q ? OP_WORD : OP_BUF;
  assign cmd_addr_o  = addr_q;
  assign cmd_data_o  = word_q ? packed_word : '0;
  assign cmd_count_o = word_q ? '0 : step_q;
  assign cmd_ptr_o   = done_q;
  assign fin_valid_o = (state_q == ST_FIN);
  assign fin_count_o = done_q;
  assign fin_err_o   = err_q;

  // R9
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o)
      && $stable(cmd_data_o) && $stable(cmd_count_o) && $stable(cmd_code_o));

  // R4
  buf_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_code_o == OP_BUF |-> cmd_addr_o[ALIGN_W-1:0] == '0
      && cmd_count_o != '0 && cmd_count_o <= CNT_W'(BUF_BYTES));

  // R2
  word_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_code_o == OP_WORD |-> cmd_addr_o[ALIGN_W-1:0] != '0
      && cmd_count_o == '0);

  // R6
  err_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_valid_o && fin_err_o |-> fin_count_o < len_q);

  // R10
  fin_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_valid_o |=> !fin_valid_o && req_ready_o);

  // R10
  fin_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_valid_o && !fin_err_o |-> fin_count_o >= len_q);
endmodule

// File: tb/test_wr_splitter.sv
module test_wr_splitter;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int BB     = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [31:0]     req_addr = '0;
  logic [15:0]     req_len = '0;
  logic [16:0]     pay_addr;
  logic [7:0]      pay_data;
  logic            cmd_valid;
  logic            cmd_ready = 1'b0;
  logic [7:0]      cmd_code;
  logic [31:0]     cmd_addr;
  logic [31:0]     cmd_data;
  logic [16:0]     cmd_count;
  logic [16:0]     cmd_ptr;
  logic            done = 1'b0;
  logic            err = 1'b0;
  logic            fin_valid;
  logic [16:0]     fin_count;
  logic            fin_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int off);
    return 8'(off * 7 + 3);
  endfunction

  assign pay_data = pat(int'(pay_addr));

  wr_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BB), .BUF_WORDS(512)) i_wr_splitter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .pay_addr_o(pay_addr), .pay_data_i(pay_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_code_o(cmd_code), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .cmd_count_o(cmd_count), .cmd_ptr_o(cmd_ptr),
    .done_i(done), .err_i(err),
    .fin_valid_o(fin_valid), .fin_count_o(fin_count), .fin_err_o(fin_err)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic start(logic [31:0] a, logic [15:0] l);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
    req_addr = a; req_len = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // waits for a command, checks fields, answers it with done/err
  task automatic expect_cmd(logic [7:0] code, logic [31:0] a, logic [31:0] d,
                            int cnt, int ptr, bit e, int hold, string req);
    int w = 0;
    while (!cmd_valid && w < 60) begin @(negedge clk); w++; end
    chk(cmd_valid == 1'b1, {req, " command offered"}, cmd_valid, 1);
    chk(cmd_code == code, {req, " code"}, cmd_code, code);
    chk(cmd_addr == a, {req, " address"}, cmd_addr, a);
    chk(cmd_data == d, {req, " data"}, cmd_data, d);
    chk(cmd_count == 17'(cnt), {req, " count"}, cmd_count, cnt);
    chk(cmd_ptr == 17'(ptr), {req, " pointer"}, cmd_ptr, ptr);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(cmd_valid && cmd_addr == a && cmd_count == 17'(cnt) && cmd_data == d,
          "R9 command held without ready", cmd_addr, a);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(cmd_valid == 1'b0, "R9 no command before done", cmd_valid, 0);
      @(negedge clk);
    end
    done = 1'b1; err = e;
    @(negedge clk);
    done = 1'b0; err = 1'b0;
  endtask

  task automatic expect_fin(int cnt, bit e, string req);
    int w = 0;
    bit saw_cmd = 1'b0;
    while (!fin_valid && w < 60) begin
      if (cmd_valid) saw_cmd = 1'b1;
      @(negedge clk); w++;
    end
    chk(fin_valid == 1'b1, {req, " completion"}, fin_valid, 1);
    chk(!saw_cmd, {req, " no extra command"}, saw_cmd, 0);
    chk(fin_count == 17'(cnt), {req, " byte count"}, fin_count, cnt);
    chk(fin_err == e, {req, " error flag"}, fin_err, e);
    @(negedge clk);
    chk(!fin_valid && req_ready, "R10 single-cycle completion", fin_valid, 0);
  endtask

  function automatic logic [31:0] word_at(int off);
    return {pat(off + 3), pat(off + 2), pat(off + 1), pat(off)};
  endfunction

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1 no command after reset", cmd_valid, 0);
    chk(fin_valid == 1'b0, "R1 no completion after reset", fin_valid, 0);
  endtask

  task automatic t_zero();
    start(32'h100, 16'd0);
    // acceptance edge lies inside start; pulse must be visible now
    chk(fin_valid == 1'b1, "R8 zero-length completes next cycle", fin_valid, 1);
    expect_fin(0, 1'b0, "R8");
  endtask

  task automatic t_aligned();
    // R7: buffer is 2048 bytes with defaults
    start(32'h1000, 16'd5000);
    expect_cmd(8'hEA, 32'h1000, 32'h0, 2048, 0, 1'b0, 0, "R4 R7 first chunk");
    expect_cmd(8'hEA, 32'h1800, 32'h0, 2048, 2048, 1'b0, 0, "R5 second chunk");
    expect_cmd(8'hEA, 32'h2000, 32'h0, 904, 4096, 1'b0, 0, "R4 short tail");
    expect_fin(5000, 1'b0, "R10 aligned");
  endtask

  task automatic t_mixed();
    start(32'h7F8, 16'd2060);
    expect_cmd(8'h42, 32'h7F8, word_at(0), 0, 0, 1'b0, 0, "R2 word lead");
    expect_cmd(8'h42, 32'h7FC, word_at(4), 0, 4, 1'b0, 0, "R3 word advance");
    expect_cmd(8'hEA, 32'h800, 32'h0, 2048, 8, 1'b0, 0, "R4 after words");
    expect_cmd(8'hEA, 32'h1000, 32'h0, 4, 2056, 1'b0, 0, "R5 tail chunk");
    expect_fin(2060, 1'b0, "R10 mixed");
  endtask

  task automatic t_overrun();
    start(32'h3, 16'd6);
    expect_cmd(8'h42, 32'h3, word_at(0), 0, 0, 1'b0, 0, "R2 odd address");
    expect_cmd(8'h42, 32'h7, word_at(4), 0, 4, 1'b0, 0, "R3 odd advance");
    expect_fin(8, 1'b0, "R10 count past length");
  endtask

  task automatic t_err_mid();
    start(32'h0, 16'd5000);
    expect_cmd(8'hEA, 32'h0, 32'h0, 2048, 0, 1'b0, 0, "R4 before error");
    expect_cmd(8'hEA, 32'h800, 32'h0, 2048, 2048, 1'b1, 0, "R6 failing chunk");
    expect_fin(2048, 1'b1, "R6 stop mid request");
  endtask

  task automatic t_err_last();
    start(32'h4000, 16'd100);
    expect_cmd(8'hEA, 32'h4000, 32'h0, 100, 0, 1'b1, 0, "R6 last chunk fails");
    expect_fin(0, 1'b1, "R6 error beats length");
  endtask

  task automatic t_hold();
    start(32'h802, 16'd2);
    expect_cmd(8'h42, 32'h802, word_at(0), 0, 0, 1'b0, 4, "R9 stalled word");
    expect_fin(4, 1'b0, "R9 after stall");
    start(32'h0, 16'd64);
    expect_cmd(8'hEA, 32'h0, 32'h0, 64, 0, 1'b0, 3, "R9 stalled buffer");
    expect_fin(64, 1'b0, "R9 buffer after stall");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_aligned();
    t_mixed();
    t_overrun();
    t_err_mid();
    t_err_last();
    t_hold();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule